// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block sits beside a serial bus engine and holds the bytes that move between it and software. It has one transmit byte queue and one receive byte queue, each 64 entries deep. Each queue has its own enable bit and a programmable trigger level. The block raises an interrupt request when the transmit queue has drained to its trigger level, so that software can refill it. It raises another when the receive queue has filled to its trigger level, so that software can drain it.

Some errors are latched until software clears them. These are a push into a full queue, a pop from an empty queue, and a pulse from the bus engine that marks the end of a transfer. A trailing timer covers the tail of a receive burst. If a few bytes sit in the receive queue below the trigger level and no new byte arrives for a programmed number of cycles, the timer raises a flag so that software can collect them.

Software sees one status word with the levels and the full and empty flags, and one interrupt status word. It clears latched bits by writing back a mask, where a one clears the bit. A single request output is the OR of every status bit that is enabled.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: `fifoCtl` bit 1 enables the TX queue and bit 0 enables the RX queue. While a queue's enable bit is low, the queue is emptied at the next clock edge. While it is low, push and pop requests to that queue are ignored and set no error flag.
- R2: Each queue holds up to 64 bytes in first-in first-out order. The pop data output always shows the oldest byte, and shows 0 when the queue is empty. A pop removes the oldest byte at the clock edge. A push and a pop in the same cycle are both carried out when the queue is neither full nor empty.
- R3: `fifoStatus` holds the following fields. TX level is in bits 6:0, TX full is bit 7 and TX empty is bit 8. RX level is in bits 22:16, RX full is bit 23 and RX empty is bit 24. All other bits read 0. Interrupt status bits 7 and 8 always read 0.
- R4: Interrupt status bit 0 (TX almost empty) is 1 exactly while TX is enabled and the TX level is less than or equal to the TX trigger level in `fifoCtl` bits 22:16.
- R5: Interrupt status bit 1 (RX almost full) is 1 exactly while RX is enabled and the RX level is greater than or equal to the RX trigger level in `fifoCtl` bits 10:4.
- R6: A push to an enabled, full queue drops the byte and sets a latched overrun bit after the edge: bit 3 for TX, bit 5 for RX. This holds even when a pop happens in the same cycle.
- R7: A pop from an enabled, empty queue leaves the queue unchanged and sets a latched underrun bit after the edge: bit 2 for TX, bit 4 for RX. A push in the same cycle is still accepted.
- R8: A trailing counter counts each cycle in which RX is enabled, receives no push request, and holds between 1 and (trigger level - 1) bytes. In any other cycle it returns to 0. The cycle in which it reaches `trailLimit` sets latched bit 6. A `trailLimit` of 0 never sets it.
- R9: A one-cycle `xferEvent` pulse sets latched bit 9.
- R10: When `clrWe` is high, each latched bit (2, 3, 4, 5, 6, 9) whose `clrData` bit is 1 is cleared at the edge. A bit that is set in the same cycle stays 1. Latched bits otherwise hold their value. Bits 0 and 1 are not affected by a clear.
- R11: `irq` is 1 exactly when some interrupt status bit and the matching `intEnable` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fifoCtl | input | 32 | Queue enables and trigger levels |
| trailLimit | input | TRAIL_W | Trailing timer limit in cycles |
| intEnable | input | 10 | Per-bit interrupt enable |
| txPush | input | 1 | Push request to the TX queue |
| txPushData | input | 8 | Byte to push into the TX queue |
| txPop | input | 1 | Pop request from the TX queue |
| txPopData | output | 8 | Oldest byte in the TX queue |
| rxPush | input | 1 | Push request to the RX queue |
| rxPushData | input | 8 | Byte to push into the RX queue |
| rxPop | input | 1 | Pop request from the RX queue |
| rxPopData | output | 8 | Oldest byte in the RX queue |
| xferEvent | input | 1 | Pulse marking the end of a transfer |
| clrWe | input | 1 | Strobe for the write-one-to-clear mask |
| clrData | input | 10 | Write-one-to-clear mask |
| fifoStatus | output | 32 | Levels and full/empty flags |
| intStatus | output | 10 | Interrupt status word |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the inputs change only away from the rising edge and that reset is held for at least one edge. They treat a push or pop request as a level that is sampled once per edge, not as a handshake. They also assume that `clrData` bits 7 and 8 carry no meaning.

The stimulus drives all inputs just after the falling edge and holds them for one full cycle. It covers both queue enable values and keeps the trigger levels within 0 to 64. It holds `trailLimit` steady while the trailing scenario runs.

// File: rtl/fic_pkg.sv
package fic_pkg;

  // Control strobes from the control unit to one queue datapath.
  typedef struct packed {
    logic wr;
    logic rd;
    logic flush;
  } fifoStrobe_t;

  localparam int ST_W  = 10;
  localparam int FLD_W = 7;

  // Bit positions in the control word.
  localparam int CTL_RXEN       = 0;
  localparam int CTL_TXEN       = 1;
  localparam int CTL_RXTRIG_LSB = 4;
  localparam int CTL_TXTRIG_LSB = 16;

  // Bit positions in the interrupt status word.
  localparam int IS_TXAE   = 0;
  localparam int IS_RXAF   = 1;
  localparam int IS_TXUNDR = 2;
  localparam int IS_TXOVR  = 3;
  localparam int IS_RXUNDR = 4;
  localparam int IS_RXOVR  = 5;
  localparam int IS_TRAIL  = 6;
  localparam int IS_XFER   = 9;

  localparam logic [ST_W-1:0] STICKY_MASK = 10'b10_0111_1100;

endpackage

// File: rtl/fic_fifo.sv
module fic_fifo
  import fic_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   stb,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic [LW-1:0] level
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [LW-1:0] levelQ;

  function automatic logic [AW-1:0] bumpPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (stb.wr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      levelQ <= '0;
    end else if (stb.flush) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      levelQ <= '0;
    end else begin
      if (stb.wr) wrPtr <= bumpPtr(wrPtr);
      if (stb.rd) rdPtr <= bumpPtr(rdPtr);
      case ({stb.wr, stb.rd})
        2'b10:   levelQ <= levelQ + LW'(1);
        2'b01:   levelQ <= levelQ - LW'(1);
        default: levelQ <= levelQ;
      endcase
    end
  end

  assign rdData = (levelQ != '0) ? mem[rdPtr] : '0;
  assign level  = levelQ;

endmodule

// File: rtl/fic_ctrl.sv
module fic_ctrl
  import fic_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int TRAIL_W = 8,
  localparam int LW  = $clog2(DEPTH + 1),
  localparam int CW  = (LW > FLD_W) ? LW : FLD_W,
  localparam int TWP = TRAIL_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txEn,
  input  logic               rxEn,
  input  logic [FLD_W-1:0]   txTrig,
  input  logic [FLD_W-1:0]   rxTrig,
  input  logic [TRAIL_W-1:0] trailLimit,
  input  logic [ST_W-1:0]    intEnable,
  input  logic               txPush,
  input  logic               txPop,
  input  logic               rxPush,
  input  logic               rxPop,
  input  logic               xferEvent,
  input  logic               clrWe,
  input  logic [ST_W-1:0]    clrData,
  input  logic [LW-1:0]      txLevel,
  input  logic [LW-1:0]      rxLevel,
  output fifoStrobe_t        txStb,
  output fifoStrobe_t        rxStb,
  output logic [ST_W-1:0]    intStatus,
  output logic               irq
);

  logic txFull, txEmpty, rxFull, rxEmpty;
  logic txAlmostEmpty, rxAlmostFull, rxBelow;
  logic [TRAIL_W-1:0] trailQ;
  logic trailClr, trailHit;
  logic [ST_W-1:0] stickyQ, setMask, clrMask;

  assign txFull  = (txLevel == LW'(DEPTH));
  assign txEmpty = (txLevel == '0);
  assign rxFull  = (rxLevel == LW'(DEPTH));
  assign rxEmpty = (rxLevel == '0);

  // Strobes towards the datapaths.
  always_comb begin
    txStb.flush = !txEn;
    txStb.wr    = txEn && txPush && !txFull;
    txStb.rd    = txEn && txPop && !txEmpty;
    rxStb.flush = !rxEn;
    rxStb.wr    = rxEn && rxPush && !rxFull;
    rxStb.rd    = rxEn && rxPop && !rxEmpty;
  end

  // Threshold comparisons.
  assign txAlmostEmpty = txEn && (CW'(txLevel) <= CW'(txTrig));
  assign rxAlmostFull  = rxEn && (CW'(rxLevel) >= CW'(rxTrig));
  assign rxBelow       = CW'(rxLevel) < CW'(rxTrig);

  // Trailing timer.
  assign trailClr = !rxEn || rxPush || rxEmpty || !rxBelow;
  assign trailHit = !trailClr && (trailQ < trailLimit) &&
                    ((TWP'(trailQ) + TWP'(1)) == TWP'(trailLimit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     trailQ <= '0;
    else if (trailClr)             trailQ <= '0;
    else if (trailQ < trailLimit)  trailQ <= trailQ + TRAIL_W'(1);
  end

  // Latched flags.
  always_comb begin
    setMask            = '0;
    setMask[IS_TXUNDR] = txEn && txPop && txEmpty;
    setMask[IS_TXOVR]  = txEn && txPush && txFull;
    setMask[IS_RXUNDR] = rxEn && rxPop && rxEmpty;
    setMask[IS_RXOVR]  = rxEn && rxPush && rxFull;
    setMask[IS_TRAIL]  = trailHit;
    setMask[IS_XFER]   = xferEvent;
    clrMask            = clrWe ? (clrData & STICKY_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stickyQ <= '0;
    else       stickyQ <= (stickyQ & ~clrMask) | (setMask & STICKY_MASK);
  end

  always_comb begin
    intStatus          = stickyQ;
    intStatus[IS_TXAE] = txAlmostEmpty;
    intStatus[IS_RXAF] = rxAlmostFull;
  end

  assign irq = |(intStatus & intEnable);

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fic_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int TRAIL_W = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        fifoCtl,
  input  logic [TRAIL_W-1:0] trailLimit,
  input  logic [ST_W-1:0]    intEnable,
  input  logic               txPush,
  input  logic [7:0]         txPushData,
  input  logic               txPop,
  output logic [7:0]         txPopData,
  input  logic               rxPush,
  input  logic [7:0]         rxPushData,
  input  logic               rxPop,
  output logic [7:0]         rxPopData,
  input  logic               xferEvent,
  input  logic               clrWe,
  input  logic [ST_W-1:0]    clrData,
  output logic [31:0]        fifoStatus,
  output logic [ST_W-1:0]    intStatus,
  output logic               irq
);

  fifoStrobe_t txStb, rxStb;
  logic [LW-1:0] txLevel, rxLevel;
  logic unusedCtl;

  assign unusedCtl = ^{fifoCtl[31:23], fifoCtl[15:11], fifoCtl[3:2]};

  fic_ctrl #(.DEPTH(DEPTH), .TRAIL_W(TRAIL_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .txEn       (fifoCtl[CTL_TXEN]),
    .rxEn       (fifoCtl[CTL_RXEN]),
    .txTrig     (fifoCtl[CTL_TXTRIG_LSB +: FLD_W]),
    .rxTrig     (fifoCtl[CTL_RXTRIG_LSB +: FLD_W]),
    .trailLimit (trailLimit),
    .intEnable  (intEnable),
    .txPush     (txPush),
    .txPop      (txPop),
    .rxPush     (rxPush),
    .rxPop      (rxPop),
    .xferEvent  (xferEvent),
    .clrWe      (clrWe),
    .clrData    (clrData),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel),
    .txStb      (txStb),
    .rxStb      (rxStb),
    .intStatus  (intStatus),
    .irq        (irq)
  );

  fic_fifo #(.DEPTH(DEPTH), .DW(8)) u_txFifo (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (txStb),
    .wrData (txPushData),
    .rdData (txPopData),
    .level  (txLevel)
  );

  fic_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (rxStb),
    .wrData (rxPushData),
    .rdData (rxPopData),
    .level  (rxLevel)
  );

  always_comb begin
    fifoStatus        = '0;
    fifoStatus[6:0]   = FLD_W'(txLevel);
    fifoStatus[7]     = (txLevel == LW'(DEPTH));
    fifoStatus[8]     = (txLevel == '0);
    fifoStatus[22:16] = FLD_W'(rxLevel);
    fifoStatus[23]    = (rxLevel == LW'(DEPTH));
    fifoStatus[24]    = (rxLevel == '0);
  end

endmodule

// File: rtl/fic_chk.sv
module fic_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] fifoCtl,
  input logic        txPush,
  input logic        rxPush,
  input logic        rxPop,
  input logic        xferEvent,
  input logic        clrWe,
  input logic [9:0]  clrData,
  input logic [31:0] fifoStatus,
  input logic [9:0]  intStatus
);

  // R6
  tx_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCtl[1] && txPush && fifoStatus[7]) |=> intStatus[3]);

  // R7
  rx_underrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCtl[0] && rxPop && fifoStatus[24]) |=> intStatus[4]);

  // R3
  tx_full_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoStatus[7] && fifoStatus[8]));

  // R1
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fifoCtl[1] |=> (fifoStatus[8] && fifoStatus[6:0] == 7'd0));

  // R1
  rx_disabled_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoCtl[0] && rxPush) |=> fifoStatus[24]);

  // R2
  rx_empty_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoStatus[24] && !rxPush) |=> fifoStatus[24]);

  // R9
  xfer_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferEvent |=> intStatus[9]);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus[5] && !(clrWe && clrData[5])) |=> intStatus[5]);

  // R10
  xfer_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrWe && clrData[9] && !xferEvent) |=> !intStatus[9]);

endmodule

bind fifo_irq_ctrl fic_chk u_fic_chk (
  .clk        (clk),
  .rstN       (rstN),
  .fifoCtl    (fifoCtl),
  .txPush     (txPush),
  .rxPush     (rxPush),
  .rxPop      (rxPop),
  .xferEvent  (xferEvent),
  .clrWe      (clrWe),
  .clrData    (clrData),
  .fifoStatus (fifoStatus),
  .intStatus  (intStatus)
);

// File: tb/test_fifo_irq_ctrl.sv
module test_fifo_irq_ctrl;

  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] fifoCtl;
  logic [7:0]  trailLimit;
  logic [9:0]  intEnable;
  logic        txPush, txPop, rxPush, rxPop;
  logic [7:0]  txPushData, rxPushData;
  logic [7:0]  txPopData, rxPopData;
  logic        xferEvent, clrWe;
  logic [9:0]  clrData;
  logic [31:0] fifoStatus;
  logic [9:0]  intStatus;
  logic        irq;

  always #2 clk = ~clk;

  fifo_irq_ctrl i_fifo_irq_ctrl (
    .clk(clk), .rstN(rstN), .fifoCtl(fifoCtl), .trailLimit(trailLimit),
    .intEnable(intEnable), .txPush(txPush), .txPushData(txPushData),
    .txPop(txPop), .txPopData(txPopData), .rxPush(rxPush),
    .rxPushData(rxPushData), .rxPop(rxPop), .rxPopData(rxPopData),
    .xferEvent(xferEvent), .clrWe(clrWe), .clrData(clrData),
    .fifoStatus(fifoStatus), .intStatus(intStatus), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  logic [9:0] mSticky;
  int mTrail;
  string bitTag[10] = '{"R4", "R5", "R7", "R6", "R7", "R6", "R8", "R3", "R3", "R9"};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expFifoStatus();
    logic [31:0] s = '0;
    s[6:0]   = 7'(txQ.size());
    s[7]     = (txQ.size() == DEPTH);
    s[8]     = (txQ.size() == 0);
    s[22:16] = 7'(rxQ.size());
    s[23]    = (rxQ.size() == DEPTH);
    s[24]    = (rxQ.size() == 0);
    return s;
  endfunction

  function automatic logic [9:0] expIntStatus();
    logic [9:0] s = mSticky;
    s[0] = fifoCtl[1] && (txQ.size() <= int'(fifoCtl[22:16]));
    s[1] = fifoCtl[0] && (rxQ.size() >= int'(fifoCtl[10:4]));
    return s;
  endfunction

  task automatic modelEdge();
    logic [9:0] setM = '0;
    int tl = txQ.size();
    int rl = rxQ.size();
    bit tclr;
    tclr = !fifoCtl[0] || rxPush || rl == 0 || rl >= int'(fifoCtl[10:4]);
    if (tclr) mTrail = 0;
    else if (mTrail < int'(trailLimit)) begin
      if (mTrail + 1 == int'(trailLimit)) setM[6] = 1'b1;
      mTrail++;
    end
    if (!fifoCtl[1]) txQ.delete();
    else begin
      if (txPop) begin
        if (tl == 0) setM[2] = 1'b1;
        else void'(txQ.pop_front());
      end
      if (txPush) begin
        if (tl == DEPTH) setM[3] = 1'b1;
        else txQ.push_back(txPushData);
      end
    end
    if (!fifoCtl[0]) rxQ.delete();
    else begin
      if (rxPop) begin
        if (rl == 0) setM[4] = 1'b1;
        else void'(rxQ.pop_front());
      end
      if (rxPush) begin
        if (rl == DEPTH) setM[5] = 1'b1;
        else rxQ.push_back(rxPushData);
      end
    end
    if (xferEvent) setM[9] = 1'b1;
    mSticky = (mSticky & ~(clrWe ? (clrData & 10'b10_0111_1100) : 10'h0)) | setM;
  endtask

  task automatic compareAll();
    logic [9:0] ei = expIntStatus();
    logic [31:0] ef = expFifoStatus();
    logic [7:0] etx = (txQ.size() != 0) ? txQ[0] : 8'h00;
    logic [7:0] erx = (rxQ.size() != 0) ? rxQ[0] : 8'h00;
    chk(fifoStatus === ef, "R3 fifoStatus", fifoStatus, ef);
    for (int b = 0; b < 10; b++)
      chk(intStatus[b] === ei[b], bitTag[b], 32'(intStatus), 32'(ei));
    chk(irq === |(ei & intEnable), "R11 irq", 32'(irq), 32'(|(ei & intEnable)));
    chk(txPopData === etx, "R2 txPopData", 32'(txPopData), 32'(etx));
    chk(rxPopData === erx, "R2 rxPopData", 32'(rxPopData), 32'(erx));
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
    txPush = 0; txPop = 0; rxPush = 0; rxPop = 0;
    xferEvent = 0; clrWe = 0; clrData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rstN = 0; fifoCtl = '0; trailLimit = 8'd15; intEnable = '0;
    txPush = 0; txPop = 0; rxPush = 0; rxPop = 0;
    txPushData = '0; rxPushData = '0; xferEvent = 0; clrWe = 0; clrData = '0;
    mSticky = '0; mTrail = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R3 reset state: both empty, no flags
    chk(fifoStatus === 32'h0100_0100, "R3 reset fifoStatus", fifoStatus, 32'h0100_0100);
    chk(intStatus === 10'h0, "R4 reset intStatus", 32'(intStatus), 0);
    compareAll();

    // enable both, TX trigger 16, RX trigger 48
    fifoCtl = 32'h0010_0303; intEnable = 10'h3ff;
    step();
    for (int i = 0; i < 70; i++) begin
      txPush = 1; txPushData = 8'(i * 3 + 1); step();
    end
    // R6 TX overrun after 70 pushes into 64 slots
    chk(intStatus[3] === 1'b1, "R6 tx overrun", 32'(intStatus), 32'h8);
    // R2 oldest byte first
    chk(txPopData === 8'd1, "R2 tx head", 32'(txPopData), 1);
    txPop = 1; txPush = 1; txPushData = 8'hAA; step();
    for (int i = 0; i < 66; i++) begin txPop = 1; step(); end
    // R7 TX underrun
    chk(intStatus[2] === 1'b1, "R7 tx underrun", 32'(intStatus), 32'h4);

    // trailing: 5 bytes below RX trigger, then silence
    for (int i = 0; i < 5; i++) begin rxPush = 1; rxPushData = 8'(8'h40 + i); step(); end
    idle(10);
    // R8 not yet at limit
    chk(intStatus[6] === 1'b0, "R8 trail early", 32'(intStatus[6]), 0);
    idle(10);
    // R8 fired
    chk(intStatus[6] === 1'b1, "R8 trail fired", 32'(intStatus[6]), 1);

    // RX fill to overrun, almost-full
    for (int i = 0; i < 62; i++) begin rxPush = 1; rxPushData = 8'(i); step(); end
    // R5 RX at/above trigger
    chk(intStatus[1] === 1'b1, "R5 rx almost full", 32'(intStatus[1]), 1);
    // R6 RX overrun
    chk(intStatus[5] === 1'b1, "R6 rx overrun", 32'(intStatus[5]), 1);

    // R10 write back status; xfer pulse in same cycle wins
    clrWe = 1; clrData = intStatus | 10'h200; xferEvent = 1; step();
    chk((intStatus & 10'b00_0111_1100) === 10'h0, "R10 cleared", 32'(intStatus), 0);
    chk(intStatus[9] === 1'b1, "R9 set wins over clear", 32'(intStatus[9]), 1);
    clrWe = 1; clrData = 10'h200; step();
    chk(intStatus[9] === 1'b0, "R10 xfer cleared", 32'(intStatus[9]), 0);
    // R11 with mask only on RX almost full
    intEnable = 10'h002; step();
    chk(irq === 1'b1, "R11 irq masked", 32'(irq), 1);
    intEnable = 10'h001; step();

    // R1 disable RX with data; pushes/pops ignored
    fifoCtl = 32'h0010_0302; step();
    chk(fifoStatus[24] === 1'b1, "R1 rx flushed", fifoStatus, 32'h0100_0000);
    rxPush = 1; rxPop = 1; step();
    chk(fifoStatus[24] === 1'b1 && intStatus[4] === 1'b0, "R1 rx ignored",
        32'(intStatus), 0);
    fifoCtl = 32'h0010_0303; trailLimit = 8'd6; intEnable = 10'h3ff; step();

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      txPush = ($urandom_range(0, 9) < 5); txPushData = 8'($urandom);
      txPop  = ($urandom_range(0, 9) < 5);
      rxPush = ($urandom_range(0, 9) < 3); rxPushData = 8'($urandom);
      rxPop  = ($urandom_range(0, 9) < 3);
      xferEvent = ($urandom_range(0, 49) == 0);
      clrWe = ($urandom_range(0, 19) == 0); clrData = 10'($urandom);
      if ($urandom_range(0, 199) == 0) fifoCtl[1:0] = 2'($urandom);
      if ($urandom_range(0, 299) == 0) begin
        fifoCtl[22:16] = 7'($urandom_range(0, 64));
        fifoCtl[10:4]  = 7'($urandom_range(0, 64));
      end
      if (fifoCtl[1:0] != 2'b11 && $urandom_range(0, 9) == 0) fifoCtl[1:0] = 2'b11;
      intEnable = 10'($urandom);
      step();
    end

    summary();
    $finish;
  end

endmodule